// File: doc/BRIEF.md
# Cascadable TDM Serial Output Stage

This block is the serial output stage of a four-channel audio converter that runs a 256-bit-clock time-division-multiplexed frame. At each frame-sync rising edge it latches four 24-bit parallel samples. It then shifts them out, most significant bit first, in the first four 32-bit slots of the frame on a single serial line.

The last four slots carry the stream of an upstream device of the same kind. That stream arrives on a cascade input and fills the first half of the same frame. The block stores those four samples in a small buffer while they arrive and sends them again in slots five to eight, which is a delay of exactly half a frame. Two devices can therefore be chained: the serial output of the first feeds the cascade input of the second, and the second device's output carries eight channels.

Everything runs on the bit clock. The cascade input and the frame sync are sampled on its rising edge, and the serial output changes on its falling edge. A cascade enable selects whether the upstream slots are sent again or driven to zero.

Top module: `tdm_cascade_serializer`

## Requirements
- R1: The frame position restarts at 0 on each frame-sync rising edge, sampled on a bit-clock rising edge. It advances by one on every later bit-clock rising edge and wraps from 255 to 0 when no new edge arrives. An early frame-sync edge cuts the current frame short and starts a new one.
- R2: The frame holds 8 slots of 32 positions each. Each slot carries a 24-bit sample, MSB first, starting at the slot's position 0. The bit for position p is driven on the bit-clock falling edge that follows the rising edge that entered p, so the first MSB of a frame appears on the falling edge just after the frame-sync edge is sampled.
- R3: Positions 24 to 31 of every slot are driven to 0.
- R4: Channel k is `local_samples[24k+23:24k]`, where k=0 is L1, k=1 is R1, k=2 is L2 and k=3 is R2. Channel k is sent in slot k (slots 0 to 3). The channels are latched at the frame-sync rising edge, and changes to `local_samples` during a frame have no effect on that frame.
- R5: The `casc_in` bit sampled on the rising edge that ends position p (p in 0..127, payload positions only) is upstream bit p. When cascade output is active, that bit is driven again at position p+128 of the same frame, so upstream slots 0 to 3 appear in slots 4 to 7.
- R6: While `cascade_en` is low, slots 4 to 7 are driven to 0. If `cascade_en` is first sampled low at the rising edge that enters position d, every position from d onward is 0.
- R7: After reset, or after `cascade_en` has been low, slots 4 to 7 stay 0 until a frame has had `cascade_en` high from its first capture position through position 119. From that frame on, including that frame, they carry the upstream samples.
- R8: Until the first frame-sync rising edge after reset, `sdata_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; 256 periods per frame |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame sync; rising edge marks the frame start |
| cascade_en | input | 1 | Enables replay of the upstream slots |
| casc_in | input | 1 | Serial TDM stream from the upstream device |
| local_samples | input | 96 | Four 24-bit local samples, channel k at bits 24k+23:24k |
| sdata_out | output | 1 | Eight-slot serial TDM output, changes on bclk falling edge |

## Verification
The frame-sync edge is seen at rising edge P0. The position register holds p after rising edge Pp, and the output for p follows on the next falling edge. The bench therefore drives `fsync` and `casc_in` on falling edges and reads `sdata_out` 2 ns after the falling edge that follows Pp, which makes received bit i-1 the one due at step i. Upstream bit p is driven on that same falling edge and sampled at P(p+1). Cascade enables and disables take effect from the position entered at the rising edge that samples them, so the expected frame is zero from that position on. Local samples are changed mid-frame, one falling edge before a non-frame-start rising edge, to show that the latch ignores them.

// File: rtl/tdm_cascade_pkg.sv
package tdm_cascade_pkg;

  localparam int DEF_SAMPLE_W = 24;
  localparam int DEF_SLOT_W   = 32;
  localparam int DEF_LOCAL_CH = 4;

  // total positions per frame: local slots plus the same count of cascade slots
  function automatic int frame_len(int slot_w, int local_ch);
    return 2 * local_ch * slot_w;
  endfunction

  // true while the position inside a slot carries sample data
  function automatic bit is_payload(int bit_in_slot, int sample_w);
    return bit_in_slot < sample_w;
  endfunction

  // MSB-first: slot position 0 maps to the top sample bit
  function automatic int msb_first_idx(int bit_in_slot, int sample_w);
    return sample_w - 1 - bit_in_slot;
  endfunction

  // frame position of the final payload bit of the last captured slot
  function automatic int last_capture_pos(int sample_w, int slot_w, int local_ch);
    return (local_ch - 1) * slot_w + sample_w - 1;
  endfunction

endpackage

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer
  import tdm_cascade_pkg::*;
#(
  parameter int FRAME_LEN = 256,
  parameter int POS_W     = 8
) (
  input  logic             bclk,
  input  logic             rst_n,
  input  logic             fsync,
  output logic             fs_rise,
  output logic             running,
  output logic [POS_W-1:0] pos
);

  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_LEN - 1);

  logic fs_q;

  assign fs_rise = fsync & ~fs_q;

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q    <= 1'b0;
      running <= 1'b0;
      pos     <= '0;
    end else begin
      fs_q <= fsync;
      if (fs_rise) begin
        running <= 1'b1;
        pos     <= '0;
      end else if (running) begin
        pos <= (pos == LAST_POS) ? '0 : pos + 1'b1;
      end
    end
  end

endmodule

// File: rtl/tdm_casc_capture.sv
module tdm_casc_capture
  import tdm_cascade_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 32,
  parameter int LOCAL_CH = 4,
  parameter int POS_W    = 8
) (
  input  logic             bclk,
  input  logic             rst_n,
  input  logic             casc_in,
  input  logic             cascade_en,
  input  logic             running,
  input  logic             fs_rise,
  input  logic [POS_W-1:0] pos,
  output logic             casc_bit,
  output logic             casc_ok,
  output logic             cap_last
);

  localparam int BIT_W    = $clog2(SLOT_W);
  localparam int CH_W     = (LOCAL_CH > 1) ? $clog2(LOCAL_CH) : 1;
  localparam int IDX_W    = (SAMPLE_W > 1) ? $clog2(SAMPLE_W) : 1;
  localparam int LAST_CAP = last_capture_pos(SAMPLE_W, SLOT_W, LOCAL_CH);

  logic [BIT_W-1:0] bitn;
  logic [CH_W-1:0]  ch;
  logic [IDX_W-1:0] idx;
  logic             upper;
  logic             payload;
  logic             cap_en;
  logic             cap_first;
  logic             arm_q;
  logic [LOCAL_CH-1:0][SAMPLE_W-1:0] buf_w;

  assign bitn      = pos[BIT_W-1:0];
  assign ch        = pos[BIT_W +: CH_W];
  assign upper     = pos[POS_W-1];
  assign payload   = is_payload(int'(bitn), SAMPLE_W);
  assign idx       = IDX_W'(msb_first_idx(int'(bitn), SAMPLE_W));
  // the bit on casc_in at this rising edge belongs to the position now held
  assign cap_en    = running & ~fs_rise & ~upper & payload;
  assign cap_first = cap_en & (pos == '0);
  assign cap_last  = cap_en & (pos == POS_W'(LAST_CAP));

  for (genvar k = 0; k < LOCAL_CH; k++) begin : g_word
    logic [SAMPLE_W-1:0] word_q;
    always_ff @(posedge bclk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (cap_en && (ch == CH_W'(k))) begin
        word_q[idx] <= casc_in;
      end
    end
    assign buf_w[k] = word_q;
  end

  // arm_q: enable seen at the first capture position of the running frame
  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q   <= 1'b0;
      casc_ok <= 1'b0;
    end else if (!cascade_en) begin
      arm_q   <= 1'b0;
      casc_ok <= 1'b0;
    end else begin
      if (cap_first) arm_q <= 1'b1;
      if (cap_last && arm_q) casc_ok <= 1'b1;
    end
  end

  assign casc_bit = casc_ok & upper & payload & buf_w[ch][idx];

endmodule

// File: rtl/tdm_slot_driver.sv
module tdm_slot_driver
  import tdm_cascade_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 32,
  parameter int LOCAL_CH = 4,
  parameter int POS_W    = 8
) (
  input  logic                         bclk,
  input  logic                         rst_n,
  input  logic                         fs_rise,
  input  logic                         running,
  input  logic [POS_W-1:0]             pos,
  input  logic [LOCAL_CH*SAMPLE_W-1:0] local_samples,
  input  logic                         casc_bit,
  output logic                         sdata_out
);

  localparam int BIT_W = $clog2(SLOT_W);
  localparam int CH_W  = (LOCAL_CH > 1) ? $clog2(LOCAL_CH) : 1;
  localparam int IDX_W = (SAMPLE_W > 1) ? $clog2(SAMPLE_W) : 1;

  logic [BIT_W-1:0] bitn;
  logic [CH_W-1:0]  ch;
  logic [IDX_W-1:0] idx;
  logic             upper;
  logic             payload;
  logic             local_bit;
  logic             next_bit;
  logic [LOCAL_CH-1:0][SAMPLE_W-1:0] lat_w;

  assign bitn    = pos[BIT_W-1:0];
  assign ch      = pos[BIT_W +: CH_W];
  assign upper   = pos[POS_W-1];
  assign payload = is_payload(int'(bitn), SAMPLE_W);
  assign idx     = IDX_W'(msb_first_idx(int'(bitn), SAMPLE_W));

  for (genvar k = 0; k < LOCAL_CH; k++) begin : g_lat
    logic [SAMPLE_W-1:0] word_q;
    always_ff @(posedge bclk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (fs_rise) begin
        word_q <= local_samples[k*SAMPLE_W +: SAMPLE_W];
      end
    end
    assign lat_w[k] = word_q;
  end

  assign local_bit = ~upper & payload & lat_w[ch][idx];
  assign next_bit  = running & (local_bit | (upper & casc_bit));

  // launch on the falling edge, half a period after the position update
  always_ff @(negedge bclk or negedge rst_n) begin
    if (!rst_n) sdata_out <= 1'b0;
    else        sdata_out <= next_bit;
  end

endmodule

// File: rtl/tdm_cascade_serializer.sv
module tdm_cascade_serializer
  import tdm_cascade_pkg::*;
#(
  parameter int SAMPLE_W = DEF_SAMPLE_W,
  parameter int SLOT_W   = DEF_SLOT_W,
  parameter int LOCAL_CH = DEF_LOCAL_CH
) (
  input  logic                         bclk,
  input  logic                         rst_n,
  input  logic                         fsync,
  input  logic                         cascade_en,
  input  logic                         casc_in,
  input  logic [LOCAL_CH*SAMPLE_W-1:0] local_samples,
  output logic                         sdata_out
);

  localparam int FRAME_LEN = frame_len(SLOT_W, LOCAL_CH);
  localparam int POS_W     = $clog2(FRAME_LEN);

  logic             fs_rise;
  logic             running;
  logic [POS_W-1:0] pos;
  logic             casc_bit;
  logic             casc_ok;
  logic             cap_last;

  tdm_frame_timer #(
    .FRAME_LEN(FRAME_LEN),
    .POS_W    (POS_W)
  ) u_timer (
    .bclk   (bclk),
    .rst_n  (rst_n),
    .fsync  (fsync),
    .fs_rise(fs_rise),
    .running(running),
    .pos    (pos)
  );

  tdm_casc_capture #(
    .SAMPLE_W(SAMPLE_W),
    .SLOT_W  (SLOT_W),
    .LOCAL_CH(LOCAL_CH),
    .POS_W   (POS_W)
  ) u_capture (
    .bclk      (bclk),
    .rst_n     (rst_n),
    .casc_in   (casc_in),
    .cascade_en(cascade_en),
    .running   (running),
    .fs_rise   (fs_rise),
    .pos       (pos),
    .casc_bit  (casc_bit),
    .casc_ok   (casc_ok),
    .cap_last  (cap_last)
  );

  tdm_slot_driver #(
    .SAMPLE_W(SAMPLE_W),
    .SLOT_W  (SLOT_W),
    .LOCAL_CH(LOCAL_CH),
    .POS_W   (POS_W)
  ) u_driver (
    .bclk         (bclk),
    .rst_n        (rst_n),
    .fs_rise      (fs_rise),
    .running      (running),
    .pos          (pos),
    .local_samples(local_samples),
    .casc_bit     (casc_bit),
    .sdata_out    (sdata_out)
  );

endmodule

// File: rtl/tdm_cascade_checker.sv
module tdm_cascade_checker
  import tdm_cascade_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 32,
  parameter int LOCAL_CH = 4,
  parameter int POS_W    = 8
) (
  input logic             bclk,
  input logic             rst_n,
  input logic             cascade_en,
  input logic             fs_rise,
  input logic             running,
  input logic [POS_W-1:0] pos,
  input logic             casc_ok,
  input logic             cap_last,
  input logic             sdata_out
);

  localparam int BIT_W     = $clog2(SLOT_W);
  localparam int FRAME_LEN = frame_len(SLOT_W, LOCAL_CH);
  localparam int LAST_CAP  = last_capture_pos(SAMPLE_W, SLOT_W, LOCAL_CH);

  p_restart_r1: assert property (@(posedge bclk) disable iff (!rst_n)
    fs_rise |=> (pos == '0) && running);

  p_advance_r1: assert property (@(posedge bclk) disable iff (!rst_n)
    (running && !fs_rise) |=>
      pos == (($past(pos) == POS_W'(FRAME_LEN - 1)) ? '0 : $past(pos) + 1'b1));

  p_pad_zero_r3: assert property (@(posedge bclk) disable iff (!rst_n)
    (int'(pos[BIT_W-1:0]) >= SAMPLE_W) |-> !sdata_out);

  p_casc_off_r6: assert property (@(posedge bclk) disable iff (!rst_n)
    !cascade_en |=> !casc_ok);

  p_casc_gate_r7: assert property (@(posedge bclk) disable iff (!rst_n)
    (!casc_ok && pos[POS_W-1]) |-> !sdata_out);

  p_casc_arm_r7: assert property (@(posedge bclk) disable iff (!rst_n)
    $rose(casc_ok) |-> $past(cascade_en) && $past(cap_last)
                       && ($past(pos) == POS_W'(LAST_CAP)));

  p_idle_zero_r8: assert property (@(posedge bclk) disable iff (!rst_n)
    !running |-> !sdata_out);

endmodule

bind tdm_cascade_serializer tdm_cascade_checker #(
  .SAMPLE_W(SAMPLE_W),
  .SLOT_W  (SLOT_W),
  .LOCAL_CH(LOCAL_CH),
  .POS_W   (POS_W)
) u_checker (
  .bclk      (bclk),
  .rst_n     (rst_n),
  .cascade_en(cascade_en),
  .fs_rise   (fs_rise),
  .running   (running),
  .pos       (pos),
  .casc_ok   (casc_ok),
  .cap_last  (cap_last),
  .sdata_out (sdata_out)
);

// File: tb/test_tdm_cascade_serializer.sv
module test_tdm_cascade_serializer;

  localparam int SW  = 24;
  localparam int SL  = 32;
  localparam int NCH = 4;
  localparam int FL  = 2 * NCH * SL;

  logic              bclk = 1'b0;
  logic              rst_n = 1'b0;
  logic              fsync = 1'b0;
  logic              cascade_en = 1'b0;
  logic              casc_in = 1'b0;
  logic [NCH*SW-1:0] local_samples = '0;
  logic              sdata_out;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 bclk = ~bclk;

  tdm_cascade_serializer i_tdm_cascade_serializer (
    .bclk         (bclk),
    .rst_n        (rst_n),
    .fsync        (fsync),
    .cascade_en   (cascade_en),
    .casc_in      (casc_in),
    .local_samples(local_samples),
    .sdata_out    (sdata_out)
  );

  // bit j (0 = first on the wire) of the slot that carries word ch
  function automatic logic slot_bit(logic [NCH*SW-1:0] words, int ch, int j);
    if (j >= SW) return 1'b0;
    return words[ch*SW + (SW - 1 - j)];
  endfunction

  task automatic check_val(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Caller enters between the falling edge that raised fsync and the next rising edge.
  task automatic run_frame(input logic [NCH*SW-1:0] lw, input logic [NCH*SW-1:0] uw,
                           input int len, input logic cen_start, input int cen_step,
                           input logic cen_after, input logic casc_valid,
                           input string ltag, input string ctag);
    logic rx [FL];
    logic ex [FL];
    logic [31:0] act;
    logic [31:0] exp;
    int pad_bad;
    local_samples = lw;
    cascade_en    = cen_start;
    for (int p = 0; p < FL; p++) begin
      int s = p / SL;
      int j = p % SL;
      if (s < NCH) begin
        ex[p] = slot_bit(lw, s, j);
      end else begin
        logic on = casc_valid;
        if (cen_step > 0 && !cen_after && p >= cen_step) on = 1'b0;
        ex[p] = on ? slot_bit(uw, s - NCH, j) : 1'b0;
      end
      rx[p] = 1'b0;
    end
    for (int i = 1; i <= len; i++) begin
      int p = i - 1;
      @(negedge bclk);
      fsync   = (i < len) ? (i < len / 2) : 1'b1;
      casc_in = (p < FL / 2) ? slot_bit(uw, p / SL, p % SL) : 1'b0;
      if (i == cen_step) cascade_en = cen_after;
      if (i == FL / 2) local_samples = ~local_samples;
      #2;
      rx[p] = sdata_out;
    end
    pad_bad = 0;
    for (int s = 0; s < 2 * NCH; s++) begin
      if ((s + 1) * SL <= len) begin
        for (int j = 0; j < SL; j++) begin
          act[SL-1-j] = rx[s*SL + j];
          exp[SL-1-j] = ex[s*SL + j];
          if (j >= SW && rx[s*SL + j]) pad_bad++;
        end
        check_val((s == 0) ? "R2" : (s < NCH) ? ltag : ctag,
                  $sformatf("slot %0d", s), act, exp);
      end
    end
    check_val("R3", "pad bits set", 32'(pad_bad), 32'd0);
  endtask

  task automatic test_reset_idle();
    int seen = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge bclk);
    rst_n = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge bclk);
      #2;
      if (sdata_out !== 1'b0) seen++;
    end
    check_val("R8", "output before first frame sync", 32'(seen), 32'd0);
    @(negedge bclk);
    fsync = 1'b1;
  endtask

  task automatic test_local_only();
    run_frame({24'h800000, 24'h000001, 24'hFFFFFF, 24'hA5C3F0},
              {24'h123456, 24'h789ABC, 24'hDEF012, 24'h345678},
              FL, 1'b0, 0, 1'b0, 1'b0, "R4", "R6");
  endtask

  task automatic test_enable_mid_frame();
    run_frame({24'h0F0F0F, 24'hF0F0F0, 24'h555555, 24'hAAAAAA},
              {24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF},
              FL, 1'b0, 60, 1'b1, 1'b0, "R4", "R7");
  endtask

  task automatic test_cascade_replay();
    run_frame({24'h13579B, 24'h2468AC, 24'hC0FFEE, 24'h000000},
              {24'h800001, 24'h7FFFFE, 24'hB1B2B3, 24'hFEDCBA},
              FL, 1'b1, 0, 1'b1, 1'b1, "R4", "R5");
    run_frame({24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF},
              {24'h000001, 24'h800000, 24'h00FF00, 24'hFF00FF},
              FL, 1'b1, 0, 1'b1, 1'b1, "R4", "R5");
  endtask

  task automatic test_disable_mid_frame();
    run_frame({24'h112233, 24'h445566, 24'h778899, 24'hAABBCC},
              {24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF},
              FL, 1'b1, 200, 1'b0, 1'b1, "R4", "R6");
  endtask

  task automatic test_short_frame_restart();
    run_frame({24'h999999, 24'h666666, 24'h333333, 24'hCCCCCC},
              {24'h0A0B0C, 24'h0D0E0F, 24'h101112, 24'h131415},
              100, 1'b1, 0, 1'b1, 1'b0, "R1", "R5");
    run_frame({24'h0000FF, 24'hFF0000, 24'h00FF00, 24'h5A5A5A},
              {24'hE1E2E3, 24'h8C8D8E, 24'h010203, 24'hC4C5C6},
              FL, 1'b1, 0, 1'b1, 1'b1, "R1", "R5");
  endtask

  initial begin
    #(200000 * 10);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog R1: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    test_reset_idle();
    test_local_only();
    test_enable_mid_frame();
    test_cascade_replay();
    test_disable_mid_frame();
    test_short_frame_restart();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule